// File: doc/BRIEF.md
# Threshold Gate with Hysteresis for Dual-Rail Logic

This block models a family of threshold gates with hysteresis in synthesizable form, for use in dual-rail, four-phase datapaths. Each gate lane has up to four single-bit inputs (A through D) and one output. The output asserts once the gate's set function is satisfied. It deasserts only after every input within the gate's fan-in has returned to zero (the NULL spacer). In every other case it keeps its previous value.

Each lane is split into three parts:
- a set-function evaluator;
- an OR-based all-zero detector across the gate's fan-in;
- a hold element, built as a register clocked by a fast emulation clock, with an active-low asynchronous clear.

A single parameter selects the gate kind from six choices. A second parameter replicates the gate into independent lanes.

Inputs are registered once. The output therefore reflects the input word applied before a clock edge immediately after that edge.

Top module: `ncl_th_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `q` is 0, and the clear takes effect without waiting for a clock edge.
- R2: If a lane's set function is true at a rising edge of `clk`, that lane's `q` bit is 1 after the edge.
- R3: If every input within a lane's fan-in is 0 at a rising edge, that lane's `q` bit is 0 after the edge.
- R4: If neither the set function nor the all-zero condition holds at a rising edge, that lane's `q` bit keeps its value.
- R5: Kind TH22 (encoding 0) has fan-in 2 and sets on A&B.
- R6: Kind TH23 (encoding 1) has fan-in 3 and sets when at least two of A, B, C are 1.
- R7: Kind AND0 (encoding 2) has fan-in 4 and sets on AB+BC+AD.
- R8: Kind TH24C (encoding 3) has fan-in 4 and sets on (A|B)&(C|D).
- R9: Kind TH34W3 (encoding 4) has fan-in 4 and sets on A+BCD, which equals a weighted threshold of 3 with weight 3 on A.
- R10: Kind XOR0 (encoding 5) has fan-in 4 and sets on AB+CD.
- R11: Inputs beyond a gate's fan-in are ignored. For TH22 that is C and D; for TH23 it is D. These inputs neither set the output nor prevent it from clearing.
- R12: Lanes are independent. Lane i uses `din[4i+3:4i]`, with A in bit 4i, B in bit 4i+1, C in bit 4i+2 and D in bit 4i+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulation clock for the hold registers |
| rst_n | input | 1 | Active-low asynchronous clear of every output |
| din | input | 4*LANES | Four inputs per lane (A in the lowest bit) |
| q | output | LANES | Gate output of each lane |

## Verification
A corrupted hold register appears at `q` right after the next clock edge, because that edge either forces a value (set or all-zero) or should leave it unchanged. A stuck or lost state is therefore visible as soon as a data word follows a spacer, or a second data word follows the first.

Errors in the fan-in mask have distinct signatures:
- a mask that is too wide keeps the output high when only ignored inputs remain;
- a mask that is too narrow clears the output while a counted input is still high.

Both show up one cycle after the offending word.

// File: rtl/ncl_gate_pkg.sv
package ncl_gate_pkg;

  typedef enum logic [2:0] {
    GK_TH22   = 3'd0,
    GK_TH23   = 3'd1,
    GK_AND0   = 3'd2,
    GK_TH24C  = 3'd3,
    GK_TH34W3 = 3'd4,
    GK_XOR0   = 3'd5
  } gate_kind_e;

  localparam int unsigned GATE_IN_W = 4;

  function automatic int unsigned gate_fanin(gate_kind_e k);
    case (k)
      GK_TH22: return 2;
      GK_TH23: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [GATE_IN_W-1:0] fanin_mask(gate_kind_e k);
    logic [GATE_IN_W-1:0] m;
    for (int i = 0; i < GATE_IN_W; i++) m[i] = (i < int'(gate_fanin(k)));
    return m;
  endfunction

  // Set function over A=x[0], B=x[1], C=x[2], D=x[3]
  function automatic logic gate_set(gate_kind_e k, logic [GATE_IN_W-1:0] x);
    logic a, b, c, d;
    {d, c, b, a} = x;
    case (k)
      GK_TH22:   return a & b;
      GK_TH23:   return (a & b) | (a & c) | (b & c);
      GK_AND0:   return (a & b) | (b & c) | (a & d);
      GK_TH24C:  return (a & c) | (a & d) | (b & c) | (b & d);
      GK_TH34W3: return a | (b & c & d);
      GK_XOR0:   return (a & b) | (c & d);
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ncl_set_fn.sv
module ncl_set_fn
  import ncl_gate_pkg::*;
#(
  parameter gate_kind_e KIND = GK_TH23
) (
  input  logic [GATE_IN_W-1:0] x_i,
  output logic                 set_o
);
  localparam logic [GATE_IN_W-1:0] MASK = fanin_mask(KIND);

  logic [GATE_IN_W-1:0] x_used;
  assign x_used = x_i & MASK;
  assign set_o  = gate_set(KIND, x_used);
endmodule

// File: rtl/ncl_null_det.sv
module ncl_null_det
  import ncl_gate_pkg::*;
#(
  parameter gate_kind_e KIND = GK_TH23
) (
  input  logic [GATE_IN_W-1:0] x_i,
  output logic                 null_o
);
  localparam logic [GATE_IN_W-1:0] MASK = fanin_mask(KIND);

  // OR across the fan-in; the spacer is seen when that OR is low
  assign null_o = ~|(x_i & MASK);
endmodule

// File: rtl/ncl_hold_cell.sv
module ncl_hold_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ncl_th_gate.sv
module ncl_th_gate
  import ncl_gate_pkg::*;
#(
  parameter gate_kind_e KIND  = GK_TH23,
  parameter int unsigned LANES = 1,
  localparam int unsigned DIN_W = LANES * GATE_IN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIN_W-1:0] din,
  output logic [LANES-1:0] q
);
  logic [LANES-1:0] set_hit;
  logic [LANES-1:0] null_all;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [GATE_IN_W-1:0] x;
    assign x = din[l*GATE_IN_W +: GATE_IN_W];

    ncl_set_fn #(.KIND(KIND)) u_set (
      .x_i   (x),
      .set_o (set_hit[l])
    );

    ncl_null_det #(.KIND(KIND)) u_null (
      .x_i    (x),
      .null_o (null_all[l])
    );

    ncl_hold_cell u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_hit[l]),
      .clr_i (null_all[l]),
      .q_o   (q[l])
    );
  end
endmodule

// File: rtl/ncl_th_gate_chk.sv
module ncl_th_gate_chk #(
  parameter int unsigned LANES = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] set_hit,
  input logic [LANES-1:0] null_all,
  input logic [LANES-1:0] q
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_NULL: assert (q == '0); // R1
  end

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_SET_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[l] |=> q[l]); // R2
    AST_NULL_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      null_all[l] |=> !q[l]); // R3
    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_hit[l] && !null_all[l]) |=> $stable(q[l])); // R4
    AST_SET_NULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_hit[l] && null_all[l])); // R2
  end
endmodule

bind ncl_th_gate ncl_th_gate_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .set_hit  (set_hit),
  .null_all (null_all),
  .q        (q)
);

// File: tb/tb_ncl_th_gate.sv
module tb_ncl_th_gate;
  import ncl_gate_pkg::*;

  localparam int LANES = 2;
  localparam int KINDS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4*LANES-1:0] din = '0;
  logic [LANES-1:0] q_k [KINDS];
  logic [LANES-1:0] exp_q [KINDS];

  int n_checks = 0;
  int n_fail = 0;
  string extra = "";
  string ktag [KINDS] = '{"R5", "R6", "R7", "R8", "R9", "R10"};

  always #5 clk = ~clk;

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    ncl_th_gate #(.KIND(gate_kind_e'(k)), .LANES(LANES)) dut (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .q     (q_k[k])
    );
  end

  // Reference set functions, phrased by counting and weighting
  function automatic bit ref_set(int k, logic [3:0] n);
    int a = n[0], b = n[1], c = n[2], d = n[3];
    case (k)
      0: return (a + b) == 2;
      1: return (a + b + c) >= 2;
      2: return b && (a || c) || (a && d);
      3: return (a || b) && (c || d);
      4: return (3 * a + b + c + d) >= 3;
      default: return (a + b == 2) || (c + d == 2);
    endcase
  endfunction

  function automatic bit ref_null(int k, logic [3:0] n);
    case (k)
      0: return n[1:0] == 2'b00;
      1: return n[2:0] == 3'b000;
      default: return n == 4'b0000;
    endcase
  endfunction

  task automatic check_all();
    for (int k = 0; k < KINDS; k++) begin
      for (int l = 0; l < LANES; l++) begin
        logic [3:0] n = din[4*l +: 4];
        string cls = ref_set(k, n) ? "R2" : (ref_null(k, n) ? "R3" : "R4");
        string ign = ((k == 0 && n[3:2] != 0) || (k == 1 && n[3] != 0)) ? " R11" : "";
        n_checks++;
        if (q_k[k][l] !== exp_q[k][l]) begin
          n_fail++;
          $display("FAIL %s %s%s%s kind%0d lane%0d din=%h: q=%b expected %b",
                   cls, ktag[k], ign, extra, k, l, din, q_k[k][l], exp_q[k][l]);
        end
      end
    end
  endtask

  task automatic apply(logic [4*LANES-1:0] v);
    @(negedge clk);
    din = v;
    @(posedge clk);
    #1;
    for (int k = 0; k < KINDS; k++)
      for (int l = 0; l < LANES; l++) begin
        logic [3:0] n = v[4*l +: 4];
        if (ref_set(k, n))       exp_q[k][l] = 1'b1;
        else if (ref_null(k, n)) exp_q[k][l] = 1'b0;
      end
    check_all();
  endtask

  task automatic check_reset();
    for (int k = 0; k < KINDS; k++) begin
      n_checks++;
      if (q_k[k] !== '0) begin
        n_fail++;
        $display("FAIL R1 kind%0d: q=%b expected %b", k, q_k[k], {LANES{1'b0}});
      end
    end
  endtask

  initial begin
    for (int k = 0; k < KINDS; k++) exp_q[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    check_reset();                     // R1: held in reset
    @(negedge clk);
    rst_n = 1'b1;
    apply('0);                         // R1/R3: stays NULL after release

    // R12: lanes carry different words at the same time
    extra = " R12";
    apply(8'h03);                      // lane0 A,B set; lane1 NULL
    apply(8'h30);                      // lane0 NULL; lane1 A,B
    apply(8'h3F);
    apply(8'h01);
    apply(8'h00);
    // R11: only ignored inputs of TH22/TH23 remain high
    extra = " R11";
    apply(8'h0F);
    apply(8'h0C);                      // TH22 clears, TH23 holds
    apply(8'h08);                      // TH23 clears too
    apply(8'h00);
    extra = "";

    // R1: asynchronous clear while outputs are high
    apply(8'hFF);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int k = 0; k < KINDS; k++) exp_q[k] = '0;
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    apply('0);

    // Sweep: data word, second data word, spacer (R2..R10)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 86; b++) begin
        apply(8'(a));
        apply(8'(b * 3));
        apply('0);
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule